// File: doc/BRIEF.md
# Edge-Selectable Pin Interrupt Detector

This block turns raw pin activity into interrupt request pulses for a downstream interrupt controller. It watches three 8-bit general-purpose ports and a dedicated non-maskable pin. Every input first passes through a stability filter, so a spike shorter than the filter window never reaches the edge logic. A transition in the active direction then produces a one-clock request pulse. Each port selects its own active direction, and so does the non-maskable pin.

Port A has its own request line. Ports B and C share a second request line. The non-maskable pin has a third line, and it is live only while its alternate-function enable is set. The filtered level of every pin is also presented on outputs. Software can read these to find which pin of a shared group fired.

Changing the direction setting of a port, or of the non-maskable pin, is itself reported as a request on that source's line. The controller is expected to latch each pulse as pending. Vectoring, masking and priority belong to the controller, not to this block.

Top module: `pin_irq_detector`

## Requirements
- R1: While `rst_n` is low, every filtered level is loaded from its pin. In the first cycles after release, no request line is high and `port_level`/`nmi_level` equal the pin values held during reset.
- R2: A pin level reaches its filtered output only after the new level is sampled on 3 consecutive clock edges. A pulse lasting 2 clocks or less changes neither the filtered level nor any request.
- R3: With the port's direction bit at 0 (rising), an enabled pin going 0→1 raises its request for exactly one cycle. The pulse is visible after the 4th rising clock edge following the pin change.
- R4: With the port's direction bit at 1 (falling), an enabled pin going 1→0 raises a one-cycle request with the same latency as R3. A 0→1 change on that pin raises nothing.
- R5: A pin whose `port_irq_en` bit is 0 never raises a request. Its filtered level on `port_level` still follows the pin.
- R6: Pins 0–7 (port A) drive only `req_port_a`. Pins 8–23 (ports B and C) drive only `req_port_bc`. Events on both groups in the same cycle raise both lines together.
- R7: Changing `port_fall[p]` raises a one-cycle pulse on that port's request line, visible after the first clock edge that samples the new value, if port p has at least one enabled pin. If it has none, nothing is raised.
- R8: `req_nmi` is raised only while `nmi_alt_en` is 1. It pulses for a filtered edge in the direction set by `nmi_fall` (0 rising, 1 falling), with R3 latency. It also pulses, with R7 latency, when `nmi_fall` changes.
- R9: `port_level` bit i and `nmi_level` always show the current filtered level of the matching pin, whether or not that pin can raise a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| port_pin | input | 24 | Raw pins; bits 8p+7..8p belong to port p (A=0, B=1, C=2) |
| port_irq_en | input | 24 | Per-pin interrupt-source enable |
| port_fall | input | 3 | Per-port active direction: 0 rising, 1 falling |
| nmi_pin | input | 1 | Raw non-maskable pin |
| nmi_alt_en | input | 1 | Non-maskable pin configured for its interrupt function |
| nmi_fall | input | 1 | Non-maskable active direction: 0 rising, 1 falling |
| port_level | output | 24 | Filtered level of each port pin |
| nmi_level | output | 1 | Filtered level of the non-maskable pin |
| req_port_a | output | 1 | One-cycle request from port A |
| req_port_bc | output | 1 | One-cycle request shared by ports B and C |
| req_nmi | output | 1 | One-cycle non-maskable request |

## Verification
A pin change driven between edges shows on the filtered level and on the request line after the fourth rising edge. A direction change shows on its request line after the first rising edge. Every directed check therefore drives at a falling edge and counts falling edges before sampling. Each pulse is checked for its line, its count and the exact step at which it appears. The random phase compares every cycle against a bench model that tracks the run length of each pin and applies the same two latencies.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;

endpackage

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
  parameter int STABLE_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = (STABLE_CLKS > 2) ? $clog2(STABLE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_CLKS - 1);

  logic          samp;
  logic [CW-1:0] run;

  // samp registers the pin; clean moves once samp has disagreed for STABLE_CLKS edges
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp  <= raw;
      clean <= raw;
      run   <= '0;
    end else begin
      samp <= raw;
      if (samp == clean) begin
        run <= '0;
      end else if (run == LAST) begin
        clean <= samp;
        run   <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/edge_sense.sv
module edge_sense
  import pin_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  logic      init_lvl,
  input  edge_pol_e pol,
  output logic      hit
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= init_lvl;
    else        prev <= lvl;
  end

  always_comb begin
    if (pol == EDGE_FALL) hit = prev & ~lvl;
    else                  hit = lvl & ~prev;
  end
endmodule

// File: rtl/polarity_track.sv
module polarity_track #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pol_in,
  output logic [W-1:0] pol_now,
  output logic [W-1:0] pol_flip
);
  logic [W-1:0] pol_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_now <= pol_in;
      pol_old <= pol_in;
    end else begin
      pol_now <= pol_in;
      pol_old <= pol_now;
    end
  end

  assign pol_flip = pol_now ^ pol_old;
endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
  import pin_irq_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int NUM_PORTS   = 3,
  parameter int STABLE_CLKS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0]   port_pin,
  input  logic [NUM_PORTS*PORT_W-1:0]   port_irq_en,
  input  logic [NUM_PORTS-1:0]          port_fall,
  input  logic                          nmi_pin,
  input  logic                          nmi_alt_en,
  input  logic                          nmi_fall,
  output logic [NUM_PORTS*PORT_W-1:0]   port_level,
  output logic                          nmi_level,
  output logic                          req_port_a,
  output logic                          req_port_bc,
  output logic                          req_nmi
);
  localparam int NPIN    = NUM_PORTS * PORT_W;
  localparam int NSRC    = NPIN + 1;
  localparam int NMI_SRC = NPIN;
  localparam int NPOL    = NUM_PORTS + 1;

  logic [NSRC-1:0]      src_raw;
  logic [NSRC-1:0]      src_lvl;
  logic [NSRC-1:0]      src_hit;
  logic [NSRC-1:0]      src_fall;
  logic [NPOL-1:0]      pol_now;
  logic [NPOL-1:0]      pol_flip;
  logic [NUM_PORTS-1:0] port_any_en;
  logic [NUM_PORTS-1:0] port_evt;

  assign src_raw = {nmi_pin, port_pin};

  polarity_track #(.W(NPOL)) u_pol (
    .clk      (clk),
    .rst_n    (rst_n),
    .pol_in   ({nmi_fall, port_fall}),
    .pol_now  (pol_now),
    .pol_flip (pol_flip)
  );

  // direction select per source: pins follow their port, the last source is the NMI pin
  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      if (gi == NMI_SRC) begin : g_nmi_pol
        assign src_fall[gi] = pol_now[NUM_PORTS];
      end else begin : g_port_pol
        assign src_fall[gi] = pol_now[gi / PORT_W];
      end

      pin_deglitch #(.STABLE_CLKS(STABLE_CLKS)) u_flt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (src_raw[gi]),
        .clean (src_lvl[gi])
      );

      edge_sense u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (src_lvl[gi]),
        .init_lvl (src_raw[gi]),
        .pol      (edge_pol_e'(src_fall[gi])),
        .hit      (src_hit[gi])
      );
    end
  endgenerate

  // per-port event: an enabled pin edge, or a direction change while the port has a live pin
  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
      assign port_any_en[gp] = |port_irq_en[gp*PORT_W +: PORT_W];
      assign port_evt[gp]    = (|(src_hit[gp*PORT_W +: PORT_W] & port_irq_en[gp*PORT_W +: PORT_W]))
                             | (pol_flip[gp] & port_any_en[gp]);
    end
  endgenerate

  assign port_level  = src_lvl[NPIN-1:0];
  assign nmi_level   = src_lvl[NMI_SRC];
  assign req_port_a  = rst_n & port_evt[0];
  assign req_port_bc = rst_n & (|port_evt[NUM_PORTS-1:1]);
  assign req_nmi     = rst_n & nmi_alt_en & (src_hit[NMI_SRC] | pol_flip[NUM_PORTS]);
endmodule

// File: rtl/pin_irq_detector_chk.sv
module pin_irq_detector_chk #(
  parameter int PORT_W      = 8,
  parameter int NUM_PORTS   = 3,
  parameter int STABLE_CLKS = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_PORTS*PORT_W-1:0] port_irq_en,
  input logic [NUM_PORTS-1:0]        port_fall,
  input logic                        nmi_pin,
  input logic                        nmi_alt_en,
  input logic [NUM_PORTS*PORT_W-1:0] port_level,
  input logic                        nmi_level,
  input logic                        req_port_a,
  input logic                        req_port_bc,
  input logic                        req_nmi
);
  localparam int NPIN = NUM_PORTS * PORT_W;

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !(req_port_a || req_port_bc || req_nmi));

  assert_a_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_port_a |-> (|port_irq_en[PORT_W-1:0]));

  assert_bc_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_port_bc |-> (|port_irq_en[NPIN-1:PORT_W]));

  assert_nmi_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_nmi |-> nmi_alt_en);

  assert_a_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_port_a |-> ((port_level[PORT_W-1:0] != $past(port_level[PORT_W-1:0]))
                    || ($past(port_fall[0]) != $past(port_fall[0], 2))));

  generate
    if (STABLE_CLKS == 3) begin : g_hold
      assert_filter_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_level != $past(nmi_level)) |->
          ((nmi_level == $past(nmi_pin, 2)) && (nmi_level == $past(nmi_pin, 3))
           && (nmi_level == $past(nmi_pin, 4))));
    end
  endgenerate
endmodule

bind pin_irq_detector pin_irq_detector_chk #(
  .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .STABLE_CLKS(STABLE_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .port_irq_en(port_irq_en), .port_fall(port_fall),
  .nmi_pin(nmi_pin), .nmi_alt_en(nmi_alt_en), .port_level(port_level),
  .nmi_level(nmi_level), .req_port_a(req_port_a), .req_port_bc(req_port_bc),
  .req_nmi(req_nmi)
);

// File: tb/test_pin_irq_detector.sv
module test_pin_irq_detector;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] port_pin = 24'h0F00F0;
  logic [23:0] port_irq_en = '0;
  logic [2:0]  port_fall = '0;
  logic        nmi_pin = 1'b0;
  logic        nmi_alt_en = 1'b0;
  logic        nmi_fall = 1'b0;
  logic [23:0] port_level;
  logic        nmi_level;
  logic        req_port_a, req_port_bc, req_nmi;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit rand_phase = 1'b0;
  int cnt_a, cnt_bc, cnt_n, at_a, at_bc, at_n;

  always #(CLK_P/2) clk = ~clk;

  pin_irq_detector i_pin_irq_detector (
    .clk(clk), .rst_n(rst_n), .port_pin(port_pin), .port_irq_en(port_irq_en),
    .port_fall(port_fall), .nmi_pin(nmi_pin), .nmi_alt_en(nmi_alt_en),
    .nmi_fall(nmi_fall), .port_level(port_level), .nmi_level(nmi_level),
    .req_port_a(req_port_a), .req_port_bc(req_port_bc), .req_nmi(req_nmi)
  );

  // bench model: run length on the raw pin, then one-edge lag to the filtered level
  logic [24:0] m_st, m_lvl, m_prev;
  logic [1:0]  m_run [25];
  logic [3:0]  m_pnow, m_pold;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st   <= {nmi_pin, port_pin};
      m_lvl  <= {nmi_pin, port_pin};
      m_prev <= {nmi_pin, port_pin};
      m_pnow <= {nmi_fall, port_fall};
      m_pold <= {nmi_fall, port_fall};
      for (int i = 0; i < 25; i++) m_run[i] <= 2'd0;
    end else begin
      for (int i = 0; i < 25; i++) begin
        if ({nmi_pin, port_pin}[i] == m_st[i]) m_run[i] <= 2'd0;
        else if (m_run[i] == 2'd2) begin
          m_st[i]  <= {nmi_pin, port_pin}[i];
          m_run[i] <= 2'd0;
        end else m_run[i] <= m_run[i] + 2'd1;
      end
      m_lvl  <= m_st;
      m_prev <= m_lvl;
      m_pnow <= {nmi_fall, port_fall};
      m_pold <= m_pnow;
    end
  end

  function automatic logic [2:0] model_reqs();
    logic [24:0] hit;
    logic [2:0]  evt;
    logic [3:0]  flip;
    flip = m_pnow ^ m_pold;
    for (int i = 0; i < 25; i++) begin
      logic f;
      f = (i == 24) ? m_pnow[3] : m_pnow[i/8];
      hit[i] = f ? (m_prev[i] & ~m_lvl[i]) : (m_lvl[i] & ~m_prev[i]);
    end
    for (int p = 0; p < 3; p++)
      evt[p] = (|(hit[p*8 +: 8] & port_irq_en[p*8 +: 8])) | (flip[p] & (|port_irq_en[p*8 +: 8]));
    return {nmi_alt_en & (hit[24] | flip[3]), evt[1] | evt[2], evt[0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // count pulses on each line over n falling edges, remembering the first step of each
  task automatic watch(input int n);
    cnt_a = 0; cnt_bc = 0; cnt_n = 0; at_a = 0; at_bc = 0; at_n = 0;
    for (int s = 1; s <= n; s++) begin
      @(negedge clk);
      if (req_port_a)  begin cnt_a++;  if (at_a == 0)  at_a = s;  end
      if (req_port_bc) begin cnt_bc++; if (at_bc == 0) at_bc = s; end
      if (req_nmi)     begin cnt_n++;  if (at_n == 0)  at_n = s;  end
    end
  endtask

  task automatic expect_lines(input string tag, input int ea, input int ebc, input int en);
    chk(cnt_a == (ea != 0) && at_a == ea, {tag, " port A"}, {cnt_a, at_a}, {(ea != 0) ? 32'd1 : 32'd0, ea});
    chk(cnt_bc == (ebc != 0) && at_bc == ebc, {tag, " port BC"}, {cnt_bc, at_bc}, {(ebc != 0) ? 32'd1 : 32'd0, ebc});
    chk(cnt_n == (en != 0) && at_n == en, {tag, " nmi"}, {cnt_n, at_n}, {(en != 0) ? 32'd1 : 32'd0, en});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired, all requirements actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1b2c);
    step(6);
    rst_n = 1'b1;
    // R1: reset loads pin levels, nothing fires
    watch(4);
    expect_lines("R1 after reset", 0, 0, 0);
    chk(port_level == 24'h0F00F0 && nmi_level == 1'b0, "R1 levels", port_level, 24'h0F00F0);

    // R3: rising edge on enabled port A pin 0
    port_irq_en[0] = 1'b1; step(2);
    port_pin[0] = 1'b1; watch(8);
    expect_lines("R3 rise pin0", 4, 0, 0);

    // R2: 2-clock spike ignored, 3-clock pulse accepted
    port_irq_en[2] = 1'b1; step(2);
    port_pin[2] = 1'b1; step(2); port_pin[2] = 1'b0; watch(8);
    expect_lines("R2 short spike", 0, 0, 0);
    chk(port_level[2] == 1'b0, "R2 spike level", port_level[2], 1'b0);
    port_pin[2] = 1'b1; watch(3); port_pin[2] = 1'b0;
    chk(cnt_a == 0, "R2 pulse not yet", cnt_a, 0);
    watch(8);
    expect_lines("R2 3-clock pulse", 1, 0, 0);

    // R7: direction change on port A with enabled pins
    port_fall[0] = 1'b1; watch(6);
    expect_lines("R7 port A flip", 1, 0, 0);

    // R4: falling selected, pin4 high->low fires, low->high does not
    port_irq_en[4] = 1'b1; step(2);
    port_pin[4] = 1'b0; watch(8);
    expect_lines("R4 fall pin4", 4, 0, 0);
    port_pin[4] = 1'b1; watch(8);
    expect_lines("R4 rise ignored", 0, 0, 0);

    // R5 / R9: disabled pin6 still tracked on port_level
    port_pin[6] = 1'b0; watch(8);
    expect_lines("R5 disabled pin", 0, 0, 0);
    chk(port_level[6] == 1'b0, "R9 disabled pin level", port_level[6], 1'b0);

    // R6: port B pin8 rising goes only to the shared line
    port_irq_en[8] = 1'b1; step(2);
    port_pin[8] = 1'b1; watch(8);
    expect_lines("R6 port B pin8", 0, 4, 0);

    // R7 on port C, then R4 falling on pin16
    port_irq_en[16] = 1'b1; step(2);
    port_fall[2] = 1'b1; watch(6);
    expect_lines("R7 port C flip", 0, 1, 0);
    port_pin[16] = 1'b0; watch(8);
    expect_lines("R4 port C fall", 0, 4, 0);

    // R7 negative: port C with no enabled pin
    port_irq_en[23:16] = '0; step(2);
    port_fall[2] = 1'b0; watch(6);
    expect_lines("R7 no enabled pin", 0, 0, 0);

    // R6: simultaneous events on both groups
    port_pin[0] = 1'b0; port_pin[8] = 1'b0; port_fall[1] = 1'b1; watch(1);
    expect_lines("R7 port B flip", 0, 1, 0);
    watch(7);
    expect_lines("R6 both groups", 3, 3, 0);

    // R8: NMI gating, direction, and direction change
    nmi_pin = 1'b1; watch(8);
    expect_lines("R8 nmi disabled", 0, 0, 0);
    chk(nmi_level == 1'b1, "R9 nmi level", nmi_level, 1'b1);
    nmi_alt_en = 1'b1; step(1);
    nmi_pin = 1'b0; watch(8);
    expect_lines("R8 nmi wrong edge", 0, 0, 0);
    nmi_pin = 1'b1; watch(8);
    expect_lines("R8 nmi rise", 0, 0, 4);
    nmi_fall = 1'b1; watch(6);
    expect_lines("R8 nmi flip", 0, 0, 1);
    nmi_pin = 1'b0; watch(8);
    expect_lines("R8 nmi fall", 0, 0, 4);

    // random phase against bench model (R2 R3 R4 R5 R6 R7 R8 R9)
    rand_phase = 1'b1;
    port_irq_en = 24'hA5_3C_81;
    for (int c = 0; c < 4000; c++) begin
      logic [2:0] exp_r;
      @(negedge clk);
      exp_r = model_reqs();
      chk({req_nmi, req_port_bc, req_port_a} == exp_r, "R6 random requests",
          {req_nmi, req_port_bc, req_port_a}, exp_r);
      chk(port_level == m_lvl[23:0] && nmi_level == m_lvl[24], "R9 random levels",
          {nmi_level, port_level}, m_lvl);
      for (int i = 0; i < 24; i++) if ($urandom_range(9) == 0) port_pin[i] = ~port_pin[i];
      if ($urandom_range(7) == 0) nmi_pin = ~nmi_pin;
      if ($urandom_range(60) == 0) port_fall = 3'($urandom_range(7));
      if ($urandom_range(90) == 0) nmi_fall = ~nmi_fall;
      if ($urandom_range(150) == 0) port_irq_en = 24'($urandom);
      if ($urandom_range(200) == 0) nmi_alt_en = ~nmi_alt_en;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule